// File: doc/BRIEF.md
# EX-Stage Operand Forwarding Unit

This block resolves read-after-write dependencies between the instruction now in the execute stage of a five-stage pipeline and the two older instructions ahead of it. For each of the two ALU operands, it compares the source register number against the destination numbers held in the execute/memory and memory/writeback stage registers. It then chooses where the operand value comes from: the register-file read value, the writeback value, or the ALU result that was just computed.

The block is purely combinational. It emits a 2-bit select per operand, and it drives the two resolved operand values through its own three-way multiplexers. An instruction forwards only if it actually writes a register and its destination is not register zero. When both older instructions target the same register, the younger one wins. A dependency three instructions apart needs no path, because the register file writes before it reads within a cycle.

Top module: `fwd_ex_unit`

## Requirements
- R1: When `exm_we` is 1, `exm_rd` is nonzero and `exm_rd` equals an operand's source register, that operand's select is 2'b10 and its value equals `exm_alu`.
- R2: When `mwb_we` is 1, `mwb_rd` is nonzero, `mwb_rd` equals an operand's source register and R1 does not apply to that operand, the select is 2'b01 and the value equals `mwb_wdata`.
- R3: When both stages would forward to the same operand, the execute/memory source wins: select 2'b10 and value `exm_alu`.
- R4: A destination number of zero never forwards, even with the write bit set and a matching source.
- R5: A stage whose write bit is 0 never forwards, whatever its destination number.
- R6: With no forwarding condition, the select is 2'b00 and the operand equals its register-file read value.
- R7: Operand A (source `id_rs`) and operand B (source `id_rt`) are decided independently, so both may forward in one cycle, from the same stage or from different stages.
- R8: The select value 2'b11 is never produced; if the mux sees it, the mux passes the register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | RW | Source register of operand A (execute stage) |
| id_rt | input | RW | Source register of operand B (execute stage) |
| exm_rd | input | RW | Destination of instruction in execute/memory register |
| exm_we | input | 1 | Register-write bit of that instruction |
| mwb_rd | input | RW | Destination of instruction in memory/writeback register |
| mwb_we | input | 1 | Register-write bit of that instruction |
| rf_rs_data | input | DW | Register-file value for operand A |
| rf_rt_data | input | DW | Register-file value for operand B |
| exm_alu | input | DW | ALU result held in execute/memory register |
| mwb_wdata | input | DW | Writeback value from memory/writeback register |
| fwd_a | output | 2 | Operand A select (00 file, 01 writeback, 10 ALU result) |
| fwd_b | output | 2 | Operand B select, same encoding |
| opnd_a | output | DW | Resolved operand A |
| opnd_b | output | DW | Resolved operand B |

## Verification
The bench targets three writes in a row to one register. A design without the younger-wins rule would hand out the stale writeback value there. It drives destination zero with the write bit set, where a design that forwards anyway would replace the constant zero with garbage. It also sets matching destinations with the write bit clear, which catches forwarding from stores and branches. Randomized register numbers drawn from a small range give frequent matches, and the results are compared against an independent priority model. The same patterns show whether A and B are decided together, which would make one operand's hit leak into the other.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_WB = 2'b01;
  localparam logic [1:0] SEL_EX = 2'b10;
  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] src_reg,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    sel
);
  logic ex_hit;
  logic wb_hit;

  always_comb begin
    ex_hit = ex_we && (ex_rd != '0) && (ex_rd == src_reg);
    wb_hit = wb_we && (wb_rd != '0) && (wb_rd == src_reg);
    if (ex_hit)      sel = SEL_EX;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  always_comb begin
    // R8: encoding 11 is never produced
    a_r8_no_sel11: assert (sel != 2'b11) else $error("select 11 produced");
    // R4: a zero destination never forwards
    a_r4_zero_rd: assert (!(sel == SEL_EX && ex_rd == '0) && !(sel == SEL_WB && wb_rd == '0))
      else $error("forward from register zero");
    // R5: non-writing stage never forwards
    a_r5_no_write: assert (!(sel == SEL_EX && !ex_we) && !(sel == SEL_WB && !wb_we))
      else $error("forward from non-writing stage");
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] wb_val,
  input  logic [DW-1:0] ex_val,
  output logic [DW-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SEL_EX:  opnd = ex_val;
      SEL_WB:  opnd = wb_val;
      default: opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_ex_unit.sv
module fwd_ex_unit
  import fwd_pkg::*;
#(
  parameter int unsigned RW = 5,
  parameter int unsigned DW = 32
) (
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic [RW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_we,
  input  logic [DW-1:0] rf_rs_data,
  input  logic [DW-1:0] rf_rt_data,
  input  logic [DW-1:0] exm_alu,
  input  logic [DW-1:0] mwb_wdata,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  logic [RW-1:0] src   [NUM_OPND];
  logic [DW-1:0] rfv   [NUM_OPND];
  logic [1:0]    sel   [NUM_OPND];
  logic [DW-1:0] res   [NUM_OPND];

  assign src[0] = id_rs;
  assign src[1] = id_rt;
  assign rfv[0] = rf_rs_data;
  assign rfv[1] = rf_rt_data;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_match #(.RW(RW)) match_i (
      .src_reg (src[g]),
      .ex_rd   (exm_rd),
      .ex_we   (exm_we),
      .wb_rd   (mwb_rd),
      .wb_we   (mwb_we),
      .sel     (sel[g])
    );
    fwd_operand_mux #(.DW(DW)) mux_i (
      .sel     (sel[g]),
      .rf_val  (rfv[g]),
      .wb_val  (mwb_wdata),
      .ex_val  (exm_alu),
      .opnd    (res[g])
    );
  end

  assign fwd_a  = sel[0];
  assign fwd_b  = sel[1];
  assign opnd_a = res[0];
  assign opnd_b = res[1];

  always_comb begin
    // R3: younger producer wins when both stages match operand A
    a_r3_ex_priority: assert (!(exm_we && exm_rd != '0 && exm_rd == id_rs) || fwd_a == SEL_EX)
      else $error("EX/MEM priority lost on A");
    // R1: EX select delivers the ALU result
    a_r1_ex_value: assert (fwd_b != SEL_EX || opnd_b == exm_alu)
      else $error("EX select gave wrong value on B");
    // R2: WB select delivers the writeback value
    a_r2_wb_value: assert (fwd_a != SEL_WB || opnd_a == mwb_wdata)
      else $error("WB select gave wrong value on A");
    // R6: no forward keeps the register-file value
    a_r6_rf_value: assert (fwd_a != SEL_RF || opnd_a == rf_rs_data)
      else $error("RF select gave wrong value on A");
  end
endmodule

// File: tb/fwd_ex_unit_tb_top.sv
module fwd_ex_unit_tb_top;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk;
  logic rst_n;
  logic [RW-1:0] id_rs, id_rt, exm_rd, mwb_rd;
  logic exm_we, mwb_we;
  logic [DW-1:0] rf_rs_data, rf_rt_data, exm_alu, mwb_wdata;
  logic [1:0] fwd_a, fwd_b;
  logic [DW-1:0] opnd_a, opnd_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fwd_ex_unit #(.RW(RW), .DW(DW)) dut_i (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [1:0] ref_sel(logic [RW-1:0] s);
    if (exm_we && exm_rd != 0 && exm_rd == s) return 2'b10;
    if (mwb_we && mwb_rd != 0 && mwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] ref_val(logic [1:0] s, logic [DW-1:0] rf);
    if (s == 2'b10) return exm_alu;
    if (s == 2'b01) return mwb_wdata;
    return rf;
  endfunction

  task automatic drive(input logic [RW-1:0] rs, rt, erd, input logic ewe,
                       input logic [RW-1:0] wrd, input logic wwe);
    @(negedge clk);
    id_rs = rs; id_rt = rt; exm_rd = erd; exm_we = ewe; mwb_rd = wrd; mwb_we = wwe;
    rf_rs_data = 32'hA000_0000 | 32'(rs);
    rf_rt_data = 32'hB000_0000 | 32'(rt);
    exm_alu    = 32'hE000_0000 | 32'(erd);
    mwb_wdata  = 32'hD000_0000 | 32'(wrd);
    #1;
  endtask

  task automatic chk(input string req, input logic [1:0] ea, eb);
    logic [DW-1:0] va, vb;
    va = ref_val(ea, rf_rs_data);
    vb = ref_val(eb, rf_rt_data);
    checks++;
    if (fwd_a !== ea || fwd_b !== eb || opnd_a !== va || opnd_b !== vb) begin
      fails++;
      $display("FAIL %s: sel a=%b b=%b opnd a=%h b=%h, expected sel a=%b b=%b opnd a=%h b=%h",
               req, fwd_a, fwd_b, opnd_a, opnd_b, ea, eb, va, vb);
    end
  endtask

  task automatic t_idle();
    drive(0, 0, 0, 0, 0, 0);
    chk("R6 idle", 2'b00, 2'b00);
    drive(3, 4, 7, 1, 9, 1);
    chk("R6 no match", 2'b00, 2'b00);
  endtask

  task automatic t_ex_fwd();
    drive(2, 5, 2, 1, 8, 1);
    chk("R1 ex to A", 2'b10, 2'b00);
    drive(6, 2, 2, 1, 0, 0);
    chk("R1 ex to B", 2'b00, 2'b10);
  endtask

  task automatic t_wb_fwd();
    drive(1, 2, 9, 1, 2, 1);
    chk("R2 wb to B", 2'b00, 2'b01);
    drive(13, 4, 0, 0, 13, 1);
    chk("R2 wb to A", 2'b01, 2'b00);
  endtask

  task automatic t_triple_add();
    drive(1, 1, 1, 1, 1, 1);
    chk("R3 same reg three times", 2'b10, 2'b10);
    drive(1, 4, 1, 1, 1, 1);
    chk("R3 priority A", 2'b10, 2'b00);
  endtask

  task automatic t_zero();
    drive(0, 0, 0, 1, 0, 1);
    chk("R4 rd zero", 2'b00, 2'b00);
    drive(0, 7, 0, 1, 7, 1);
    chk("R4 zero ex, wb on B", 2'b00, 2'b01);
  endtask

  task automatic t_nowrite();
    drive(5, 6, 5, 0, 6, 0);
    chk("R5 no write", 2'b00, 2'b00);
    drive(5, 5, 5, 0, 5, 1);
    chk("R5 ex silent, wb wins", 2'b01, 2'b01);
  endtask

  task automatic t_both();
    drive(3, 12, 3, 1, 12, 1);
    chk("R7 A ex B wb", 2'b10, 2'b01);
    drive(12, 3, 3, 1, 12, 1);
    chk("R7 A wb B ex", 2'b01, 2'b10);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      drive(5'($urandom_range(0, 5)), 5'($urandom_range(0, 5)), 5'($urandom_range(0, 5)),
            1'($urandom), 5'($urandom_range(0, 5)), 1'($urandom));
      chk("R8 random vs model", ref_sel(id_rs), ref_sel(id_rt));
      checks++;
      if (fwd_a == 2'b11 || fwd_b == 2'b11) begin
        fails++;
        $display("FAIL R8: sel a=%b b=%b expected not 11", fwd_a, fwd_b);
      end
    end
  endtask

  initial begin
    rst_n = 0;
    drive(0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    rst_n = 1;
    t_idle();
    t_ex_fwd();
    t_wb_fwd();
    t_triple_add();
    t_zero();
    t_nowrite();
    t_both();
    t_random();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule